// File: doc/BRIEF.md
# Switch Register Access Sequencer over MDIO

This block gives a 32-bit read/write path into the register space of an Ethernet switch that can only be reached through 16-bit MDIO management transactions. A requester hands over one register byte address and, for writes, one 32-bit word. The sequencer turns that request into three MDIO sub-accesses. The first selects a page. The second and third each move one 16-bit half of the word to or from a register pair on a pseudo-PHY. The pseudo-PHY address and the register pair are both derived from the byte address.

The MDIO serialiser is a separate block. This sequencer drives it through a command port with valid/ready handshaking and waits for its response pulse. Each sub-access has a watchdog counter. If the serialiser reports an error, or fails to answer in time, the remaining sub-accesses are dropped and the error is returned. A few switch registers latch their contents when one particular half is written. For that reason the order of the two halves in a write depends on the target address.

Top module: `swreg_mdio_bridge`

## Requirements
- R1: Every request begins with an MDIO write to PHY 0x1F, register 0x10, whose 16-bit data is the request address shifted right by 9, zero-extended.
- R2: Both half-word sub-accesses use PHY address 0x10 ORed with address bits [8:6].
- R3: The low half (bits 15:0) uses register number ((address >> 1) & 0x1E). The high half (bits 31:16) uses that number ORed with 1.
- R4: A read fetches the low register first and then the high register. The response data places the first result in bits 15:0 and the second in bits 31:16.
- R5: A write whose address equals LOW_FIRST_ADDR (default 0x98) sends the low half first. A write to any other address sends the high half first. This includes addresses that share only the low bits with LOW_FIRST_ADDR.
- R6: If the MDIO response of any sub-access carries the error flag, no further sub-access of that request is issued. The response then carries rsp_err = 1.
- R7: A sub-access is abandoned when it has not completed within TIMEOUT_LIMIT cycles of being issued. No further sub-access is issued, and the response carries rsp_err = 1.
- R8: req_ready is high only while idle. It falls after a request is accepted and stays low until the single-cycle rsp_valid pulse, after which the block is idle again.
- R9: While reset is held and directly after it, req_ready = 1, rsp_valid = 0 and mdio_cmd_valid = 0.
- R10: While mdio_cmd_valid is high and mdio_cmd_ready is low, the command stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Switch register byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Sequence aborted by error or timeout |
| mdio_cmd_valid | output | 1 | MDIO command offered |
| mdio_cmd_ready | input | 1 | Serialiser takes the command |
| mdio_cmd_write | output | 1 | 1 = MDIO write, 0 = MDIO read |
| mdio_cmd_phy | output | 5 | MDIO PHY address |
| mdio_cmd_reg | output | 5 | MDIO register number |
| mdio_cmd_wdata | output | 16 | MDIO write data |
| mdio_rsp_valid | input | 1 | Serialiser completion pulse |
| mdio_rsp_rdata | input | 16 | MDIO read data |
| mdio_rsp_err | input | 1 | Serialiser reports failure |

## Verification
The bench builds the block with ADDR_W = 18 and TIMEOUT_LIMIT = 16. The 18-bit address carries a 9-bit page, so a high-page address checks the page value and the pseudo-PHY bits separately. The short timeout lets a hung serialiser trip the watchdog within a few dozen cycles, and lets the bench bound the abort time. The MDIO model adds a response delay, an optional ready stall, and error or hang injection at any sub-access. These cover every abort point and the command-hold rule.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam logic [4:0] PAGE_PHY   = 5'h1F;
    localparam logic [4:0] PAGE_REG   = 5'h10;
    localparam logic [1:0] PHY_PREFIX = 2'b10;
    localparam int         PAGE_SHIFT = 9;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regno;
        logic [15:0] data;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        STEP_PAGE   = 2'd0,
        STEP_FIRST  = 2'd1,
        STEP_SECOND = 2'd2
    } step_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_RESP
    } seq_state_t;

    typedef enum logic [1:0] {
        SA_IDLE,
        SA_CMD,
        SA_WAIT
    } sub_state_t;

    function automatic logic [15:0] pick_half(logic [31:0] w, logic hi);
        return hi ? w[31:16] : w[15:0];
    endfunction

endpackage

// File: rtl/swreg_addr_xlate.sv
module swreg_addr_xlate
    import swreg_pkg::*;
#(
    parameter int                ADDR_W         = 18,
    parameter logic [ADDR_W-1:0] LOW_FIRST_ADDR = 'h98
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  step_t             step,
    output mdio_cmd_t         cmd,
    output logic              half_hi
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [PAGE_W-1:0] page;
    logic              low_first;

    assign page      = addr[ADDR_W-1:PAGE_SHIFT];
    assign low_first = !wr || (addr == LOW_FIRST_ADDR);

    always_comb begin
        half_hi = 1'b0;
        cmd     = '0;
        if (step == STEP_PAGE) begin
            cmd.wr               = 1'b1;
            cmd.phy              = PAGE_PHY;
            cmd.regno            = PAGE_REG;
            cmd.data[PAGE_W-1:0] = page;
        end else begin
            half_hi   = (step == STEP_SECOND) ? low_first : !low_first;
            cmd.wr    = wr;
            cmd.phy   = {PHY_PREFIX, addr[8:6]};
            cmd.regno = {addr[5:2], half_hi};
            cmd.data  = wr ? pick_half(wdata, half_hi) : 16'h0000;
        end
    end

endmodule

// File: rtl/swreg_mdio_sub.sv
module swreg_mdio_sub
    import swreg_pkg::*;
#(
    parameter int TIMEOUT_LIMIT = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdio_cmd_valid,
    input  logic        mdio_cmd_ready,
    output logic        mdio_cmd_write,
    output logic [4:0]  mdio_cmd_phy,
    output logic [4:0]  mdio_cmd_reg,
    output logic [15:0] mdio_cmd_wdata,
    input  logic        mdio_rsp_valid,
    input  logic [15:0] mdio_rsp_rdata,
    input  logic        mdio_rsp_err
);
    localparam int               CNT_W    = $clog2(TIMEOUT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(TIMEOUT_LIMIT - 1);
    localparam logic [CNT_W-1:0] LIMIT_V  = CNT_W'(TIMEOUT_LIMIT);

    sub_state_t       state;
    mdio_cmd_t        cmd_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SA_IDLE;
            cmd_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SA_IDLE: begin
                    if (start) begin
                        cmd_q <= cmd;
                        cnt   <= '0;
                        err   <= 1'b0;
                        state <= SA_CMD;
                    end
                end
                SA_CMD: begin
                    if (mdio_cmd_ready) begin
                        cnt   <= cnt + 1'b1;
                        state <= SA_WAIT;
                    end else if (cnt >= LIMIT_M1) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= SA_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SA_WAIT: begin
                    if (mdio_rsp_valid) begin
                        done  <= 1'b1;
                        err   <= mdio_rsp_err;
                        rdata <= mdio_rsp_rdata;
                        state <= SA_IDLE;
                    end else if (cnt >= LIMIT_M1) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= SA_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SA_IDLE;
            endcase
        end
    end

    assign busy           = (state != SA_IDLE);
    assign mdio_cmd_valid = (state == SA_CMD);
    assign mdio_cmd_write = cmd_q.wr;
    assign mdio_cmd_phy   = cmd_q.phy;
    assign mdio_cmd_reg   = cmd_q.regno;
    assign mdio_cmd_wdata = cmd_q.data;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mdio_cmd_valid && !mdio_cmd_ready && cnt < LIMIT_M1) |=>
        (mdio_cmd_valid && $stable({mdio_cmd_write, mdio_cmd_phy, mdio_cmd_reg, mdio_cmd_wdata})))
        else $error("command changed while stalled"); // R10

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LIMIT_V))
        else $error("timeout counter overran"); // R7

endmodule

// File: rtl/swreg_seq.sv
module swreg_seq
    import swreg_pkg::*;
#(
    parameter int                ADDR_W         = 18,
    parameter logic [ADDR_W-1:0] LOW_FIRST_ADDR = 'h98
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              sub_start,
    output mdio_cmd_t         sub_cmd,
    input  logic              sub_busy,
    input  logic              sub_done,
    input  logic              sub_err,
    input  logic [15:0]       sub_rdata
);
    seq_state_t        state;
    step_t             step;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [31:0]       wdata_q;
    logic [31:0]       rdata_q;
    logic              err_q;
    logic              half_hi;

    swreg_addr_xlate #(
        .ADDR_W        (ADDR_W),
        .LOW_FIRST_ADDR(LOW_FIRST_ADDR)
    ) u_xlate (
        .addr   (addr_q),
        .wr     (wr_q),
        .wdata  (wdata_q),
        .step   (step),
        .cmd    (sub_cmd),
        .half_hi(half_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            step    <= STEP_PAGE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        rdata_q <= '0;
                        err_q   <= 1'b0;
                        step    <= STEP_PAGE;
                        state   <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (sub_done) begin
                        if (sub_err) begin
                            err_q <= 1'b1;
                            state <= SQ_RESP;
                        end else begin
                            if (!wr_q && step != STEP_PAGE) begin
                                if (half_hi) rdata_q[31:16] <= sub_rdata;
                                else         rdata_q[15:0]  <= sub_rdata;
                            end
                            if (step == STEP_SECOND) begin
                                state <= SQ_RESP;
                            end else begin
                                step  <= step_t'(step + 2'd1);
                                state <= SQ_ISSUE;
                            end
                        end
                    end
                end
                SQ_RESP: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign req_ready = (state == SQ_IDLE);
    assign sub_start = (state == SQ_ISSUE);
    assign rsp_valid = (state == SQ_RESP);
    assign rsp_err   = rsp_valid && err_q;
    assign rsp_rdata = rdata_q;

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("response longer than one cycle"); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready stayed high after acceptance"); // R8

    AST_ONE_SUB: assert property (@(posedge clk) disable iff (rst)
        sub_start |-> !sub_busy)
        else $error("sub-access started while one is open"); // R8

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        (sub_done && sub_err) |=> (rsp_valid && rsp_err))
        else $error("error did not abort the sequence"); // R6

endmodule

// File: rtl/swreg_mdio_bridge.sv
module swreg_mdio_bridge
    import swreg_pkg::*;
#(
    parameter int                ADDR_W         = 18,
    parameter logic [ADDR_W-1:0] LOW_FIRST_ADDR = 'h98,
    parameter int                TIMEOUT_LIMIT  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              mdio_cmd_valid,
    input  logic              mdio_cmd_ready,
    output logic              mdio_cmd_write,
    output logic [4:0]        mdio_cmd_phy,
    output logic [4:0]        mdio_cmd_reg,
    output logic [15:0]       mdio_cmd_wdata,
    input  logic              mdio_rsp_valid,
    input  logic [15:0]       mdio_rsp_rdata,
    input  logic              mdio_rsp_err
);
    mdio_cmd_t   sub_cmd;
    logic        sub_start;
    logic        sub_busy;
    logic        sub_done;
    logic        sub_err;
    logic [15:0] sub_rdata;

    swreg_seq #(
        .ADDR_W        (ADDR_W),
        .LOW_FIRST_ADDR(LOW_FIRST_ADDR)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err),
        .sub_start(sub_start),
        .sub_cmd  (sub_cmd),
        .sub_busy (sub_busy),
        .sub_done (sub_done),
        .sub_err  (sub_err),
        .sub_rdata(sub_rdata)
    );

    swreg_mdio_sub #(
        .TIMEOUT_LIMIT(TIMEOUT_LIMIT)
    ) u_sub (
        .clk           (clk),
        .rst           (rst),
        .start         (sub_start),
        .cmd           (sub_cmd),
        .busy          (sub_busy),
        .done          (sub_done),
        .err           (sub_err),
        .rdata         (sub_rdata),
        .mdio_cmd_valid(mdio_cmd_valid),
        .mdio_cmd_ready(mdio_cmd_ready),
        .mdio_cmd_write(mdio_cmd_write),
        .mdio_cmd_phy  (mdio_cmd_phy),
        .mdio_cmd_reg  (mdio_cmd_reg),
        .mdio_cmd_wdata(mdio_cmd_wdata),
        .mdio_rsp_valid(mdio_rsp_valid),
        .mdio_rsp_rdata(mdio_rsp_rdata),
        .mdio_rsp_err  (mdio_rsp_err)
    );

endmodule

// File: tb/swreg_mdio_bridge_bench.sv
module swreg_mdio_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int TMO        = 16;
    localparam int WAIT_MAX   = 400;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic              mdio_cmd_valid;
    logic              mdio_cmd_ready;
    logic              mdio_cmd_write;
    logic [4:0]        mdio_cmd_phy;
    logic [4:0]        mdio_cmd_reg;
    logic [15:0]       mdio_cmd_wdata;
    logic              mdio_rsp_valid = 1'b0;
    logic [15:0]       mdio_rsp_rdata = '0;
    logic              mdio_rsp_err = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    // MDIO model configuration, written only by the stimulus
    int cfg_stall  = 0;
    int cfg_delay  = 2;
    int cfg_err_at = -1;
    int cfg_hang_at = -1;

    // MDIO model state and command log
    int          log_n = 0;
    int          stall_left = 0;
    logic        pend = 1'b0;
    int          dly = 0;
    logic        perr = 1'b0;
    logic [15:0] pdata = '0;
    logic        log_wr   [64];
    logic [4:0]  log_phy  [64];
    logic [4:0]  log_reg  [64];
    logic [15:0] log_data [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    swreg_mdio_bridge #(
        .ADDR_W       (ADDR_W),
        .TIMEOUT_LIMIT(TMO)
    ) u_swreg_mdio_bridge (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err       (rsp_err),
        .mdio_cmd_valid(mdio_cmd_valid),
        .mdio_cmd_ready(mdio_cmd_ready),
        .mdio_cmd_write(mdio_cmd_write),
        .mdio_cmd_phy  (mdio_cmd_phy),
        .mdio_cmd_reg  (mdio_cmd_reg),
        .mdio_cmd_wdata(mdio_cmd_wdata),
        .mdio_rsp_valid(mdio_rsp_valid),
        .mdio_rsp_rdata(mdio_rsp_rdata),
        .mdio_rsp_err  (mdio_rsp_err)
    );

    function automatic logic [15:0] model_val(logic [4:0] phy, logic [4:0] rg);
        return 16'hC000 | (16'(phy) << 5) | 16'(rg);
    endfunction

    assign mdio_cmd_ready = (stall_left == 0);

    always @(posedge clk) begin
        if (rst) begin
            stall_left     <= cfg_stall;
            pend           <= 1'b0;
            mdio_rsp_valid <= 1'b0;
            mdio_rsp_err   <= 1'b0;
        end else begin
            mdio_rsp_valid <= 1'b0;
            mdio_rsp_err   <= 1'b0;
            if (mdio_cmd_valid && stall_left == 0) begin
                log_wr[log_n % 64]   <= mdio_cmd_write;
                log_phy[log_n % 64]  <= mdio_cmd_phy;
                log_reg[log_n % 64]  <= mdio_cmd_reg;
                log_data[log_n % 64] <= mdio_cmd_wdata;
                log_n      <= log_n + 1;
                stall_left <= cfg_stall;
                if (log_n != cfg_hang_at) begin
                    pend  <= 1'b1;
                    dly   <= cfg_delay;
                    perr  <= (log_n == cfg_err_at);
                    pdata <= model_val(mdio_cmd_phy, mdio_cmd_reg);
                end
            end else if (mdio_cmd_valid && stall_left != 0) begin
                stall_left <= stall_left - 1;
            end
            if (pend) begin
                if (dly == 0) begin
                    mdio_rsp_valid <= 1'b1;
                    mdio_rsp_err   <= perr;
                    mdio_rsp_rdata <= perr ? 16'hFFFF : pdata;
                    pend           <= 1'b0;
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one request, wait for its response, check the handshake (R8)
    task automatic do_txn(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output int ncmd,
                          output int cyc, output int base);
        logic ready_leak;
        @(negedge clk);
        base = log_n;
        chk("R8 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        ready_leak = 1'b0;
        while (!rsp_valid && cyc < WAIT_MAX) begin
            if (req_ready) ready_leak = 1'b1;
            @(negedge clk);
            cyc++;
        end
        chk("R8 watchdog response arrived", 32'(rsp_valid), 32'd1);
        chk("R8 ready low while busy", 32'(ready_leak), 32'd0);
        chk("R8 ready low at response", 32'(req_ready), 32'd0);
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        chk("R8 response one cycle", 32'(rsp_valid), 32'd0);
        chk("R8 ready after response", 32'(req_ready), 32'd1);
        ncmd = log_n - base;
    endtask

    task automatic chk_page(input int idx, input logic [ADDR_W-1:0] a);
        chk("R1 page write flag", 32'(log_wr[idx % 64]), 32'd1);
        chk("R1 page phy", 32'(log_phy[idx % 64]), 32'h1F);
        chk("R1 page reg", 32'(log_reg[idx % 64]), 32'h10);
        chk("R1 page data", 32'(log_data[idx % 64]), 32'(a >> 9));
    endtask

    task automatic t_reset;
        chk("R9 ready in reset", 32'(req_ready), 32'd1);
        chk("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R9 cmd_valid in reset", 32'(mdio_cmd_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 ready after reset", 32'(req_ready), 32'd1);
        chk("R9 cmd_valid after reset", 32'(mdio_cmd_valid), 32'd0);
    endtask

    task automatic t_read(input logic [ADDR_W-1:0] a);
        logic [31:0] rd;
        logic        er;
        int          n, cyc, b;
        logic [4:0]  ephy, ebase;
        ephy  = 5'h10 | 5'((a >> 6) & 7);
        ebase = 5'((a >> 1) & 'h1E);
        do_txn(1'b0, a, 32'h0, rd, er, n, cyc, b);
        chk("R4 read command count", 32'(n), 32'd3);
        chk_page(b, a);
        chk("R2 first half phy", 32'(log_phy[(b+1) % 64]), 32'(ephy));
        chk("R2 second half phy", 32'(log_phy[(b+2) % 64]), 32'(ephy));
        chk("R4 first access is read", 32'(log_wr[(b+1) % 64]), 32'd0);
        chk("R3 first read reg low", 32'(log_reg[(b+1) % 64]), 32'(ebase));
        chk("R4 second read reg high", 32'(log_reg[(b+2) % 64]), 32'(ebase | 5'd1));
        chk("R4 read data", rd, {model_val(ephy, ebase | 5'd1), model_val(ephy, ebase)});
        chk("R6 no error on clean read", 32'(er), 32'd0);
    endtask

    task automatic t_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic low_first);
        logic [31:0] rd;
        logic        er;
        int          n, cyc, b;
        logic [4:0]  ebase;
        ebase = 5'((a >> 1) & 'h1E);
        do_txn(1'b1, a, d, rd, er, n, cyc, b);
        chk("R5 write command count", 32'(n), 32'd3);
        chk_page(b, a);
        chk("R5 halves are writes", 32'(log_wr[(b+1) % 64] & log_wr[(b+2) % 64]), 32'd1);
        if (low_first) begin
            chk("R5 low-first reg 1", 32'(log_reg[(b+1) % 64]), 32'(ebase));
            chk("R5 low-first data 1", 32'(log_data[(b+1) % 64]), 32'(d[15:0]));
            chk("R5 low-first reg 2", 32'(log_reg[(b+2) % 64]), 32'(ebase | 5'd1));
            chk("R5 low-first data 2", 32'(log_data[(b+2) % 64]), 32'(d[31:16]));
        end else begin
            chk("R5 high-first reg 1", 32'(log_reg[(b+1) % 64]), 32'(ebase | 5'd1));
            chk("R5 high-first data 1", 32'(log_data[(b+1) % 64]), 32'(d[31:16]));
            chk("R3 high-first reg 2", 32'(log_reg[(b+2) % 64]), 32'(ebase));
            chk("R3 high-first data 2", 32'(log_data[(b+2) % 64]), 32'(d[15:0]));
        end
        chk("R6 no error on clean write", 32'(er), 32'd0);
    endtask

    task automatic t_err(input logic wr, input int at);
        logic [31:0] rd;
        logic        er;
        int          n, cyc, b;
        cfg_err_at = log_n + at;
        do_txn(wr, 18'h00124, 32'h1234_5678, rd, er, n, cyc, b);
        cfg_err_at = -1;
        chk("R6 error flagged", 32'(er), 32'd1);
        chk("R6 sequence cut short", 32'(n), 32'(at + 1));
    endtask

    task automatic t_timeout(input int at);
        logic [31:0] rd;
        logic        er;
        int          n, cyc, b;
        cfg_hang_at = log_n + at;
        do_txn(1'b0, 18'h001C8, 32'h0, rd, er, n, cyc, b);
        cfg_hang_at = -1;
        chk("R7 timeout flagged", 32'(er), 32'd1);
        chk("R7 no access after timeout", 32'(n), 32'(at + 1));
        chk("R7 abort not before limit", 32'(cyc >= TMO), 32'd1);
        chk("R7 abort soon after limit", 32'(cyc <= TMO + 10 * (at + 1) + 10), 32'd1);
    endtask

    task automatic t_stall;
        cfg_stall = 3;
        repeat (2) @(negedge clk);
        t_read(18'h00254);
        t_write(18'h00098, 32'hA5A5_5A5A, 1'b1);
        cfg_stall = 0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_read(18'h0010C);
        t_read(18'h3F2C4);
        t_write(18'h00098, 32'hDEAD_BEEF, 1'b1);
        t_write(18'h00040, 32'h0102_0304, 1'b0);
        t_write(18'h00050, 32'hCAFE_F00D, 1'b0);
        t_write(18'h10098, 32'h8765_4321, 1'b0);
        t_err(1'b0, 0);
        t_err(1'b0, 1);
        t_err(1'b1, 2);
        t_timeout(1);
        t_timeout(0);
        t_read(18'h0003C);
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int total_cyc = 0;
    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", total_cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule